// File: doc/BRIEF.md
# Fixed-Latency Memory Bridge with Wait-State Insertion

This block sits between an APB requester and a synchronous memory (an SRAM or register file) whose read data comes back a fixed number of cycles after a request. The block notices a transfer in its first cycle, when select is high and enable is low. In that same cycle it sends one request to the memory port, carrying the write flag, the address and the write data. It then stretches the access phase by keeping the ready output low. For a read, ready stays low until the memory's read-valid strobe has been seen. For a write, it stays low for a programmable write latency.

On a read, the returned word is registered on the edge where read-valid is sampled. Ready rises in the following cycle, so a read with memory latency `RD_LAT` costs exactly `RD_LAT` wait cycles. Once a transfer completes, the bridge returns to idle and can take a new transfer in the very next cycle. The error output is tied low.

Top module: `apb_memwait_bridge`

## Requirements
- R1: After reset, `apb_ready` is high, `apb_rdata` is zero and `mem_req` is low. `apb_ready` is high in every cycle where `apb_sel` is low. `apb_slverr` is low at all times.
- R2: In the first cycle of a transfer (`apb_sel`=1, `apb_enable`=0, bridge idle), `mem_req` is high. In that cycle `mem_we` equals `apb_write`, `mem_addr` equals `apb_addr`, and `mem_wdata` equals `apb_wdata`. `mem_req` is low in every other cycle.
- R3: For a read, `apb_ready` is low for exactly `RD_LAT` access-phase cycles and high in the next one. The memory raises `mem_rvalid` `RD_LAT` cycles after the request.
- R4: At read completion, `apb_rdata` equals the `mem_rdata` word that was presented with `mem_rvalid`. `apb_rdata` keeps that value until the next read captures a new word, and writes do not alter it.
- R5: A read never completes before `mem_rvalid` has been seen during that transfer.
- R6: For a write, `apb_ready` is low for exactly `WR_LAT` access-phase cycles. `WR_LAT`=0 completes the write in its first access cycle.
- R7: After a completion the bridge is idle again. A new transfer whose first cycle immediately follows the completion cycle is accepted with the same timing as an isolated one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apb_sel | input | 1 | Transfer select |
| apb_enable | input | 1 | Access-phase marker |
| apb_write | input | 1 | 1 = write, 0 = read |
| apb_addr | input | ADDR_W | Word address |
| apb_wdata | input | DATA_W | Write data |
| apb_rdata | output | DATA_W | Registered read data |
| apb_ready | output | 1 | Completion / wait indication |
| apb_slverr | output | 1 | Error response, always 0 |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_rvalid | input | 1 | Read data valid strobe |

## Verification
The bench targets these corner cases:
- Wait count off by one. A design that registers the request instead of issuing it in the first cycle would insert one wait too many. A design that raises ready on the read-valid cycle itself would insert one wait too few. The bench counts low-ready cycles on every read and every write.
- Read data. The bench checks returned words against a reference array across both address extremes and after overwrites. A bridge that captured data on the wrong cycle, or let a write disturb the held read word, would return stale data.
- Back-to-back transfers. The bench chains transfers with no idle cycle between them. A design that needs an extra idle cycle would drop or misalign the second request.
- Idle ready level. Long idle stretches check that ready stays high, so the bridge never stalls the bus when it is not selected.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    MW_IDLE    = 2'd0,
    MW_RD_WAIT = 2'd1,
    MW_WR_WAIT = 2'd2,
    MW_DONE    = 2'd3
  } mw_state_e;
endpackage

// File: rtl/mw_setup_decode.sv
// Detects the first cycle of a transfer and drives the memory request port.
module mw_setup_decode #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              idle,
  input  logic              apb_sel,
  input  logic              apb_enable,
  input  logic              apb_write,
  input  logic [ADDR_W-1:0] apb_addr,
  input  logic [DATA_W-1:0] apb_wdata,
  output logic              setup_hit,
  output logic              setup_is_wr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  always_comb begin
    setup_hit   = idle && apb_sel && !apb_enable;
    setup_is_wr = setup_hit && apb_write;
    mem_req     = setup_hit;
    mem_we      = setup_is_wr;
    mem_addr    = setup_hit ? apb_addr : '0;
    mem_wdata   = setup_is_wr ? apb_wdata : '0;
  end
endmodule

// File: rtl/mw_seq_fsm.sv
// Transfer sequencer: read waits follow the memory's valid strobe,
// write waits follow a fixed down-counter.
module mw_seq_fsm
  import mw_pkg::*;
#(
  parameter int WR_LAT = 1,
  parameter int CNT_W  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_hit,
  input  logic setup_is_wr,
  input  logic rd_valid,
  output logic idle,
  output logic capture,
  output logic ready
);
  localparam logic [CNT_W-1:0] WR_LOAD = (WR_LAT == 0) ? '0 : CNT_W'(WR_LAT - 1);

  mw_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      MW_IDLE: begin
        if (setup_hit) begin
          if (!setup_is_wr) begin
            state_d = MW_RD_WAIT;
          end else if (WR_LAT == 0) begin
            state_d = MW_DONE;
          end else begin
            state_d = MW_WR_WAIT;
            cnt_d   = WR_LOAD;
            cnt_en  = 1'b1;
          end
        end
      end
      MW_RD_WAIT: begin
        if (rd_valid) state_d = MW_DONE;
      end
      MW_WR_WAIT: begin
        if (cnt_q == '0) begin
          state_d = MW_DONE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      MW_DONE: state_d = MW_IDLE;
      default: state_d = MW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MW_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    idle    = (state_q == MW_IDLE);
    capture = (state_q == MW_RD_WAIT) && rd_valid;
    ready   = (state_q == MW_IDLE) || (state_q == MW_DONE);
  end
endmodule

// File: rtl/mw_rdata_reg.sv
// Read-data holding register, loaded only on the capture strobe.
module mw_rdata_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = capture ? mem_rdata : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/apb_memwait_bridge.sv
module apb_memwait_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apb_sel,
  input  logic              apb_enable,
  input  logic              apb_write,
  input  logic [ADDR_W-1:0] apb_addr,
  input  logic [DATA_W-1:0] apb_wdata,
  output logic [DATA_W-1:0] apb_rdata,
  output logic              apb_ready,
  output logic              apb_slverr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid
);
  localparam int LAT_MAX = 7;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  if (RD_LAT < 1 || RD_LAT > LAT_MAX) begin : g_bad_rd_lat
    $error("RD_LAT must lie in 1..7");
  end
  if (WR_LAT < 0 || WR_LAT > LAT_MAX) begin : g_bad_wr_lat
    $error("WR_LAT must lie in 0..7");
  end

  logic idle;
  logic setup_hit;
  logic setup_is_wr;
  logic capture;

  mw_setup_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .idle        (idle),
    .apb_sel     (apb_sel),
    .apb_enable  (apb_enable),
    .apb_write   (apb_write),
    .apb_addr    (apb_addr),
    .apb_wdata   (apb_wdata),
    .setup_hit   (setup_hit),
    .setup_is_wr (setup_is_wr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  mw_seq_fsm #(.WR_LAT(WR_LAT), .CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_hit   (setup_hit),
    .setup_is_wr (setup_is_wr),
    .rd_valid    (mem_rvalid),
    .idle        (idle),
    .capture     (capture),
    .ready       (apb_ready)
  );

  mw_rdata_reg #(.DATA_W(DATA_W)) u_rdata (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .mem_rdata (mem_rdata),
    .rdata     (apb_rdata)
  );

  assign apb_slverr = 1'b0;
endmodule

// File: rtl/mw_checker.sv
module mw_checker #(
  parameter int DATA_W = 32,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              apb_sel,
  input logic              apb_enable,
  input logic              apb_write,
  input logic              apb_ready,
  input logic [DATA_W-1:0] apb_rdata,
  input logic              mem_req,
  input logic              mem_rvalid
);
  logic [3:0] wait_cnt;
  logic       seen_valid;
  logic       first_cyc;
  logic       access_end;

  assign first_cyc  = apb_sel && !apb_enable;
  assign access_end = apb_sel && apb_enable && apb_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt   <= '0;
      seen_valid <= 1'b0;
    end else begin
      if (first_cyc) begin
        wait_cnt   <= '0;
        seen_valid <= 1'b0;
      end else begin
        if (apb_sel && apb_enable && !apb_ready && wait_cnt != 4'hF)
          wait_cnt <= wait_cnt + 4'd1;
        if (mem_rvalid) seen_valid <= 1'b1;
      end
    end
  end

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !apb_sel |-> apb_ready);

  p_req_first_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (apb_sel && !apb_enable));

  p_read_starts_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_cyc && !apb_write) |=> !apb_ready);

  p_read_wait_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (access_end && !apb_write) |-> (wait_cnt == 4'(RD_LAT)));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rvalid |=> $stable(apb_rdata));

  p_valid_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (access_end && !apb_write) |-> seen_valid);

  p_write_wait_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (access_end && apb_write) |-> (wait_cnt == 4'(WR_LAT)));
endmodule

bind apb_memwait_bridge mw_checker #(
  .DATA_W (DATA_W),
  .RD_LAT (RD_LAT),
  .WR_LAT (WR_LAT)
) u_mw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .apb_sel    (apb_sel),
  .apb_enable (apb_enable),
  .apb_write  (apb_write),
  .apb_ready  (apb_ready),
  .apb_rdata  (apb_rdata),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid)
);

// File: tb/test_apb_memwait_bridge.sv
`timescale 1ns/1ps
module test_apb_memwait_bridge;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int RD_LAT = 2;
  localparam int WR_LAT = 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              apb_sel, apb_enable, apb_write;
  logic [ADDR_W-1:0] apb_addr;
  logic [DATA_W-1:0] apb_wdata;
  logic [DATA_W-1:0] apb_rdata;
  logic              apb_ready, apb_slverr;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_rvalid;

  always #2.5 clk = ~clk;

  apb_memwait_bridge #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
  ) i_apb_memwait_bridge (
    .clk(clk), .rst_n(rst_n),
    .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
    .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(apb_rdata),
    .apb_ready(apb_ready), .apb_slverr(apb_slverr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  function automatic logic [DATA_W-1:0] pattern(input int i);
    return (i * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  // Memory model: fixed read latency, writes take effect at the request edge.
  logic [DATA_W-1:0] mdl_mem [DEPTH];
  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [RD_LAT-1:0] v_pipe;
  logic [DATA_W-1:0] d_pipe [RD_LAT];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mdl_mem[i] <= pattern(i);
      for (int i = 0; i < RD_LAT; i++) d_pipe[i] <= '0;
      v_pipe <= '0;
    end else begin
      v_pipe[0] <= mem_req && !mem_we;
      d_pipe[0] <= mdl_mem[mem_addr];
      for (int i = 1; i < RD_LAT; i++) begin
        v_pipe[i] <= v_pipe[i-1];
        d_pipe[i] <= d_pipe[i-1];
      end
      if (mem_req && mem_we) mdl_mem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rvalid = v_pipe[RD_LAT-1];
  assign mem_rdata  = mem_rvalid ? d_pipe[RD_LAT-1] : 32'hDEAD_BEEF;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;
  logic [DATA_W-1:0] last_rd;
  logic [15:0]       lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] next_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // One transfer. Entered 1 ns after a rising edge; leaves 1 ns after the edge
  // that ends the completion cycle, with select dropped.
  task automatic xfer(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      output logic [DATA_W-1:0] rd, output int waits, output bit rv_seen);
    apb_sel = 1'b1; apb_enable = 1'b0; apb_write = wr; apb_addr = a; apb_wdata = d;
    #1;
    chk(mem_req === 1'b1 && mem_we === wr, "R2 request/we", {30'd0, mem_req, mem_we}, {30'd0, 1'b1, wr});
    chk(mem_addr === a, "R2 address", 32'(mem_addr), 32'(a));
    if (wr) chk(mem_wdata === d, "R2 write data", mem_wdata, d);
    @(posedge clk); #1;
    apb_enable = 1'b1;
    #1;
    chk(mem_req === 1'b0, "R2 single request", 32'(mem_req), 32'd0);
    waits = 0; rv_seen = 0;
    while (apb_ready !== 1'b1 && waits < 16) begin
      if (mem_rvalid === 1'b1) rv_seen = 1;
      waits++;
      @(posedge clk); #2;
    end
    rd = apb_rdata;
    chk(apb_slverr === 1'b0, "R1 no error", 32'(apb_slverr), 32'd0);
    @(posedge clk); #1;
    apb_sel = 1'b0; apb_enable = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] rd; int w; bit rv;
    xfer(1'b0, a, '0, rd, w, rv);
    chk(w == RD_LAT, "R3 read wait count", 32'(w), 32'(RD_LAT));
    chk(rd === ref_mem[a], "R4 read data", rd, ref_mem[a]);
    chk(rv, "R5 valid seen before completion", 32'(rv), 32'd1);
    last_rd = ref_mem[a];
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] rd; int w; bit rv;
    xfer(1'b1, a, d, rd, w, rv);
    chk(w == WR_LAT, "R6 write wait count", 32'(w), 32'(WR_LAT));
    chk(rd === last_rd, "R4 read data held over write", rd, last_rd);
    ref_mem[a] = d;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; apb_sel = 0; apb_enable = 0; apb_write = 0; apb_addr = '0; apb_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(apb_ready === 1'b1, "R1 reset ready", 32'(apb_ready), 32'd1);
    chk(apb_rdata === '0, "R1 reset rdata", apb_rdata, 32'd0);
    chk(mem_req === 1'b0, "R1 reset request", 32'(mem_req), 32'd0);
    @(posedge clk); #0.5 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      apb_addr = ADDR_W'(i * 37); apb_write = i[0];
      #1;
      chk(apb_ready === 1'b1, "R1 idle ready", 32'(apb_ready), 32'd1);
      chk(mem_req === 1'b0, "R2 no request while unselected", 32'(mem_req), 32'd0);
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reads;
    do_read('0);
    @(posedge clk); #1;
    do_read({ADDR_W{1'b1}});
    repeat (2) @(posedge clk); #1;
    do_read(8'h5A);
  endtask

  task automatic t_writes;
    do_write(8'h10, 32'h1234_5678);
    @(posedge clk); #1;
    do_write({ADDR_W{1'b1}}, 32'hFFFF_0001);
    @(posedge clk); #1;
    do_read(8'h10);
    @(posedge clk); #1;
    do_read({ADDR_W{1'b1}});
    do_write(8'h10, 32'h0BAD_F00D);
    @(posedge clk); #1;
    do_read(8'h10);
  endtask

  task automatic t_back_to_back;
    // R7: each transfer starts in the cycle right after the previous completion.
    do_read(8'h01);
    do_read(8'h02);
    do_write(8'h03, 32'hCAFE_0003);
    do_read(8'h03);
    do_write(8'h04, 32'h0000_0044);
    do_write(8'h05, 32'h0000_0055);
    do_read(8'h04);
    chk(apb_ready === 1'b1, "R7 idle after chain", 32'(apb_ready), 32'd1);
  endtask

  task automatic t_mix;
    for (int i = 0; i < 60; i++) begin
      lfsr = next_lfsr(lfsr);
      if (lfsr[0]) do_write(lfsr[15:8], {lfsr, ~lfsr});
      else         do_read(lfsr[15:8]);
      if (lfsr[1]) begin
        @(posedge clk); #1;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = pattern(i);
    last_rd = '0;
    t_reset();
    t_idle();
    t_reads();
    t_writes();
    t_back_to_back();
    t_mix();
    t_idle();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule